// File: doc/BRIEF.md
# ATM Cell Change-Detection FIFO

This block watches 53-byte ATM cells arriving on several links, one byte per clock, and compares every new cell byte by byte with the cell that came before it on the same link. Each byte whose value changed produces one entry in a FIFO owned by that link. The entry records the byte's position in the cell (1 to 53), the new value, and a flag marking the last changed byte of that cell. Software can then see exactly which bytes of a repeating cell stream moved, without storing whole cells.

A host side shows a status word with one not-empty bit per link and lets software pop one entry per read from the link it selects. Each popped word also says whether that link's FIFO still holds more entries. A global enable switches capture on and off. A mode input restricts comparison to cells that an input strobe marks as ICP cells. The first cell on a link after reset or after enabling only loads the reference copy. A full FIFO drops further entries for its link and raises a sticky overflow bit.

Top module: `cell_delta_fifo`

## Requirements
- R1: For each cell on a link that has a stored reference, an entry is produced for every byte whose value differs from the same position of the previous cell on that link, and for no other byte. Entries come out in increasing byte position.
- R2: A popped word carries the new byte value in bits 7:0 and its position in the cell, 1 to 53, in bits 13:8.
- R3: Bit 14 of a popped word is 1 for the last changed byte of its cell and 0 when more entries from the same cell follow. This holds when the last changed byte is byte 53.
- R4: Bit 15 of a popped word is 0 when that entry was the last one held in the link's FIFO, and 1 when more entries remain.
- R5: `link_status` bit i is 1 when link i's FIFO holds at least one entry and 0 when it is empty. Bits at and above the link count read 0.
- R6: While `dbg_en` is 0, cells produce no entries and every link loses its stored reference.
- R7: With `icp_only` at 1, only cells whose `cell_icp` is 1 at the start-of-cell byte are compared or update the reference. Other cells are ignored completely. With `icp_only` at 0, every cell is used.
- R8: After reset `rd_word` reads 0x8000. A pop of an empty FIFO returns 0x8000 and changes no FIFO.
- R9: The first cell used on a link after reset, or after `dbg_en` returns to 1, only loads the reference and produces no entries.
- R10: A FIFO holds 64 entries. Entries arriving when it is full are dropped, and that link's `link_ovf` bit is set and stays set until reset.
- R11: A pop (`rd_en` with `rd_link`) removes one entry from the selected FIFO, and the word appears on `rd_word` after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Global capture enable |
| icp_only | input | 1 | 1: compare only ICP-marked cells; 0: compare all cells |
| cell_valid | input | 1 | A cell byte is present this cycle |
| cell_sop | input | 1 | Present byte is byte 1 of a cell |
| cell_icp | input | 1 | Cell is an ICP cell (sampled with cell_sop) |
| cell_link | input | LINK_W | Link of the cell (sampled with cell_sop) |
| cell_byte | input | 8 | Cell byte value |
| rd_en | input | 1 | Pop one entry from the link given by rd_link |
| rd_link | input | LINK_W | Link to pop |
| rd_word | output | 16 | {more, last-of-cell, position[5:0], value[7:0]} |
| link_status | output | 16 | Per-link not-empty bits |
| link_ovf | output | NUM_LINKS | Sticky per-link overflow bits |

## Verification
The bench goes after a change at byte 53, which needs a one-cycle deferred flush. A design that got this wrong would lose that entry or give the wrong cell its end flag. It also sends back-to-back cells on two links where the end of one cell and byte 1 of the next both differ, which catches pending entries pushed to the wrong link. In ICP-only mode it checks that an ignored cell leaves the reference alone: a design that updated it anyway would produce entries for the next, unchanged ICP cell. A 106-change burst into one FIFO checks the drop point, the sticky overflow bit and the more flag on the 64th pop. Empty pops and re-enabling check that no entries come from a stale or missing reference.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  localparam int CELL_LEN = 53;
  localparam int OFF_W    = 6;

  typedef struct packed {
    logic             eoc;
    logic [OFF_W-1:0] off;
    logic [7:0]       data;
  } cdf_entry_t;
endpackage

// File: rtl/cdf_ref_cmp.sv
module cdf_ref_cmp
  import cdf_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_en,
  input  logic              icp_only,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_icp,
  input  logic [LINK_W-1:0] in_link,
  input  logic [7:0]        in_byte,
  output logic              s1_cmp,
  output logic              s1_diff,
  output logic [OFF_W-1:0]  s1_off,
  output logic [7:0]        s1_byte,
  output logic [LINK_W-1:0] s1_link
);
  localparam int MEM_D  = NUM_LINKS * CELL_LEN;
  localparam int ADDR_W = $clog2(MEM_D);

  logic [7:0]           ref_mem [MEM_D];
  logic [7:0]           ref_q;
  logic [NUM_LINKS-1:0] primed;
  logic                 in_cell;
  logic [LINK_W-1:0]    cur_link;
  logic [OFF_W-1:0]     cur_off;
  logic                 cur_cmp, cur_upd;

  logic                 acc;
  logic [LINK_W-1:0]    s0_link;
  logic [OFF_W-1:0]     s0_off;
  logic                 s0_upd, s0_cmp;
  logic [ADDR_W-1:0]    s0_addr;

  always_comb begin
    acc     = in_valid && (in_sop || in_cell);
    s0_link = in_sop ? in_link : cur_link;
    s0_off  = in_sop ? OFF_W'(1) : cur_off + OFF_W'(1);
    s0_upd  = in_sop ? (dbg_en && (!icp_only || in_icp)) : cur_upd;
    s0_cmp  = in_sop ? (s0_upd && primed[in_link]) : cur_cmp;
    s0_addr = ADDR_W'(s0_link) * ADDR_W'(CELL_LEN) + ADDR_W'(s0_off) - ADDR_W'(1);
  end

  // read-first memory: block RAM friendly
  always_ff @(posedge clk) begin
    if (acc) begin
      ref_q <= ref_mem[s0_addr];
      if (s0_upd) ref_mem[s0_addr] <= in_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= '0;
      in_cell  <= 1'b0;
      cur_link <= '0;
      cur_off  <= '0;
      cur_cmp  <= 1'b0;
      cur_upd  <= 1'b0;
      s1_cmp   <= 1'b0;
      s1_off   <= '0;
      s1_byte  <= '0;
      s1_link  <= '0;
    end else begin
      if (!dbg_en) primed <= '0;
      else if (acc && in_sop && s0_upd) primed[in_link] <= 1'b1;
      if (acc) begin
        cur_link <= s0_link;
        cur_off  <= s0_off;
        cur_cmp  <= s0_cmp;
        cur_upd  <= s0_upd;
        in_cell  <= (s0_off != OFF_W'(CELL_LEN));
      end
      s1_cmp  <= acc && s0_cmp;
      s1_off  <= s0_off;
      s1_byte <= in_byte;
      s1_link <= s0_link;
    end
  end

  assign s1_diff = s1_cmp && (ref_q != s1_byte);

  AST_CMP_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    s1_cmp |-> (s1_off >= OFF_W'(1) && s1_off <= OFF_W'(CELL_LEN))); // R2

  AST_NO_CMP_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop && !dbg_en) |=> !s1_cmp); // R6
endmodule

// File: rtl/cdf_framer.sv
module cdf_framer
  import cdf_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_cmp,
  input  logic              s1_diff,
  input  logic [OFF_W-1:0]  s1_off,
  input  logic [7:0]        s1_byte,
  input  logic [LINK_W-1:0] s1_link,
  output logic              push,
  output logic [LINK_W-1:0] push_link,
  output cdf_entry_t        push_ent
);
  logic              pend_vld, fin_vld;
  logic [OFF_W-1:0]  pend_off, fin_off;
  logic [7:0]        pend_byte, fin_byte;
  logic [LINK_W-1:0] pend_link, fin_link;
  logic              last;

  assign last = s1_cmp && (s1_off == OFF_W'(CELL_LEN));

  always_comb begin
    push      = 1'b0;
    push_link = pend_link;
    push_ent  = '{eoc: 1'b0, off: pend_off, data: pend_byte};
    if (fin_vld) begin
      push      = 1'b1;
      push_link = fin_link;
      push_ent  = '{eoc: 1'b1, off: fin_off, data: fin_byte};
    end else if (s1_cmp && pend_vld && (s1_diff || last)) begin
      push         = 1'b1;
      push_ent.eoc = last && !s1_diff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      fin_vld   <= 1'b0;
      pend_off  <= '0;
      pend_byte <= '0;
      pend_link <= '0;
      fin_off   <= '0;
      fin_byte  <= '0;
      fin_link  <= '0;
    end else begin
      fin_vld <= 1'b0;
      if (s1_cmp) begin
        if (s1_diff && !last) begin
          pend_vld  <= 1'b1;
          pend_off  <= s1_off;
          pend_byte <= s1_byte;
          pend_link <= s1_link;
        end else if (s1_diff) begin
          pend_vld <= 1'b0;
          fin_vld  <= 1'b1;
          fin_off  <= s1_off;
          fin_byte <= s1_byte;
          fin_link <= s1_link;
        end else if (last) begin
          pend_vld <= 1'b0;
        end
      end
    end
  end

  AST_FIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fin_vld |=> !fin_vld); // R3

  AST_FIN_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
    fin_vld |-> !pend_vld); // R3

  AST_PUSH_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_ent.off >= OFF_W'(1) && push_ent.off <= OFF_W'(CELL_LEN))); // R2
endmodule

// File: rtl/cdf_link_fifo.sv
module cdf_link_fifo
  import cdf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  cdf_entry_t push_ent,
  input  logic       pop,
  output cdf_entry_t dout,
  output logic       dout_more,
  output logic       nonempty,
  output logic       ovf
);
  cdf_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             full, do_wr, do_rd;

  assign full     = (count == CNT_W'(DEPTH));
  assign nonempty = (count != '0);
  assign do_wr    = push && !full;
  assign do_rd    = pop && nonempty;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= push_ent;
    if (do_rd) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      ovf       <= 1'b0;
      dout_more <= 1'b0;
    end else begin
      if (do_wr) wptr <= nxt(wptr);
      if (do_rd) begin
        rptr      <= nxt(rptr);
        dout_more <= (count > CNT_W'(1));
      end
      if (push && full) ovf <= 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(wptr) && full); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R10

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !nonempty) |=> $stable(rptr)); // R8
endmodule

// File: rtl/cell_delta_fifo.sv
module cell_delta_fifo
  import cdf_pkg::*;
#(
  parameter int NUM_LINKS  = 8,
  parameter int FIFO_DEPTH = 64,
  localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int STAT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dbg_en,
  input  logic                 icp_only,
  input  logic                 cell_valid,
  input  logic                 cell_sop,
  input  logic                 cell_icp,
  input  logic [LINK_W-1:0]    cell_link,
  input  logic [7:0]           cell_byte,
  input  logic                 rd_en,
  input  logic [LINK_W-1:0]    rd_link,
  output logic [15:0]          rd_word,
  output logic [STAT_W-1:0]    link_status,
  output logic [NUM_LINKS-1:0] link_ovf
);
  logic              s1_cmp, s1_diff;
  logic [OFF_W-1:0]  s1_off;
  logic [7:0]        s1_byte;
  logic [LINK_W-1:0] s1_link;
  logic              push;
  logic [LINK_W-1:0] push_link;
  cdf_entry_t        push_ent;

  cdf_entry_t           f_dout [NUM_LINKS];
  logic [NUM_LINKS-1:0] f_more, f_ne;
  logic [LINK_W-1:0]    rd_sel_q;
  logic                 rd_show_q;

  cdf_ref_cmp #(.NUM_LINKS(NUM_LINKS)) u_cmp (
    .clk(clk), .rst(rst), .dbg_en(dbg_en), .icp_only(icp_only),
    .in_valid(cell_valid), .in_sop(cell_sop), .in_icp(cell_icp),
    .in_link(cell_link), .in_byte(cell_byte),
    .s1_cmp(s1_cmp), .s1_diff(s1_diff), .s1_off(s1_off),
    .s1_byte(s1_byte), .s1_link(s1_link)
  );

  cdf_framer #(.NUM_LINKS(NUM_LINKS)) u_frm (
    .clk(clk), .rst(rst), .s1_cmp(s1_cmp), .s1_diff(s1_diff),
    .s1_off(s1_off), .s1_byte(s1_byte), .s1_link(s1_link),
    .push(push), .push_link(push_link), .push_ent(push_ent)
  );

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_fifo
    cdf_link_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .push(push && (push_link == LINK_W'(i))),
      .push_ent(push_ent),
      .pop(rd_en && (rd_link == LINK_W'(i))),
      .dout(f_dout[i]), .dout_more(f_more[i]),
      .nonempty(f_ne[i]), .ovf(link_ovf[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q  <= '0;
      rd_show_q <= 1'b0;
    end else if (rd_en) begin
      rd_sel_q  <= rd_link;
      rd_show_q <= f_ne[rd_link];
    end
  end

  assign rd_word     = rd_show_q ? {f_more[rd_sel_q], f_dout[rd_sel_q]} : 16'h8000;
  assign link_status = STAT_W'(f_ne);

  AST_EMPTY_READ_WORD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !link_status[rd_link]) |=> (rd_word == 16'h8000)); // R8

  AST_POP_GIVES_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && link_status[rd_link]) |=> (rd_word[13:8] != 6'd0)); // R11

  AST_LAST_POP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && link_status[rd_link] && !push) |=>
      (rd_word[15] == link_status[rd_sel_q])); // R4
endmodule

// File: tb/cell_delta_fifo_tb.sv
module cell_delta_fifo_tb;
  localparam int NL = 8;
  localparam int DEPTH = 64;
  localparam int CL = 53;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbg_en = 1'b0, icp_only = 1'b0;
  logic cell_valid = 1'b0, cell_sop = 1'b0, cell_icp = 1'b0;
  logic [2:0] cell_link = '0, rd_link = '0;
  logic [7:0] cell_byte = '0;
  logic rd_en = 1'b0;
  logic [15:0] rd_word, link_status;
  logic [NL-1:0] link_ovf;

  int nchk = 0, nbad = 0;
  bit done = 0;

  logic [7:0]  cbuf [CL];
  logic [7:0]  mref [NL][CL];
  bit          mprimed [NL];
  logic [14:0] expq [NL][$];
  logic [NL-1:0] ovf_exp = '0;

  always #5 clk = ~clk;

  cell_delta_fifo #(.NUM_LINKS(NL), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .dbg_en(dbg_en), .icp_only(icp_only),
    .cell_valid(cell_valid), .cell_sop(cell_sop), .cell_icp(cell_icp),
    .cell_link(cell_link), .cell_byte(cell_byte),
    .rd_en(rd_en), .rd_link(rd_link), .rd_word(rd_word),
    .link_status(link_status), .link_ovf(link_ovf)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int base);
    for (int i = 0; i < CL; i++) cbuf[i] = 8'(base + i * 3);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cell_valid = 1'b0; cell_sop = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_dbg(input logic v);
    @(negedge clk);
    dbg_en = v;
    if (!v) for (int l = 0; l < NL; l++) mprimed[l] = 0;
  endtask

  // drives cbuf onto link l and updates the bench model
  task automatic send_cell(input int l, input logic icp);
    int idx [CL];
    int nd = 0;
    for (int i = 0; i < CL; i++) begin
      @(negedge clk);
      cell_valid = 1'b1; cell_sop = (i == 0); cell_icp = icp;
      cell_link = 3'(l); cell_byte = cbuf[i];
    end
    if (dbg_en && (!icp_only || icp)) begin
      if (mprimed[l]) begin
        for (int i = 0; i < CL; i++)
          if (mref[l][i] != cbuf[i]) begin idx[nd] = i; nd++; end
        for (int k = 0; k < nd; k++) begin
          if (expq[l].size() < DEPTH)
            expq[l].push_back({(k == nd - 1), 6'(idx[k] + 1), cbuf[idx[k]]});
          else ovf_exp[l] = 1'b1;
        end
      end
      for (int i = 0; i < CL; i++) mref[l][i] = cbuf[i];
      mprimed[l] = 1;
    end
  endtask

  task automatic pop_one(input int l, output logic [15:0] w);
    @(negedge clk);
    rd_en = 1'b1; rd_link = 3'(l);
    @(negedge clk);
    rd_en = 1'b0;
    w = rd_word;
  endtask

  // R2 R3 R4 R11: every popped word against the model; R8: empty pop
  task automatic drain(input int l, input string tag);
    logic [15:0] w;
    while (expq[l].size() > 0) begin
      logic [14:0] e;
      e = expq[l].pop_front();
      pop_one(l, w);
      chk("R2/R3/R4/R11", tag, w, {(expq[l].size() > 0), e});
    end
    chk("R5", {tag, " status after drain"}, link_status[l], 1'b0);
    pop_one(l, w);
    chk("R8", {tag, " empty pop"}, w, 16'h8000);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "reset rd_word", rd_word, 16'h8000);
    chk("R5", "reset status", link_status, 16'h0000);
    chk("R10", "reset ovf", link_ovf, '0);
  endtask

  task automatic t_prime_and_diffs;
    set_dbg(1'b1);
    fill(10); send_cell(0, 1'b0); idle(4);
    chk("R9", "first cell no entries", link_status, 16'h0000);
    cbuf[0] = 8'hA5; cbuf[19] = 8'h3C; cbuf[39] = 8'hFF;
    send_cell(0, 1'b0); idle(4);
    chk("R5", "status link0", link_status, 16'h0001);
    chk("R1", "three entries", expq[0].size(), 3);
    drain(0, "R1 three diffs");
    send_cell(0, 1'b0); idle(4);
    chk("R1", "identical cell no entries", link_status, 16'h0000);
  endtask

  task automatic t_last_byte;
    cbuf[51] = 8'h11; cbuf[52] = 8'h22;
    send_cell(0, 1'b0); idle(4);
    drain(0, "R3 bytes 52,53");
    cbuf[52] = 8'h77;
    send_cell(0, 1'b0); idle(4);
    drain(0, "R3 byte 53 only");
  endtask

  task automatic t_multi_link;
    fill(40); send_cell(2, 1'b0);
    fill(90); send_cell(5, 1'b0);
    fill(40); cbuf[5] = 8'h01; cbuf[52] = 8'h02; send_cell(2, 1'b0);
    fill(90); cbuf[0] = 8'h03; cbuf[30] = 8'h04; send_cell(5, 1'b0);
    idle(4);
    chk("R5", "status links 2,5", link_status, 16'h0024);
    drain(2, "R1 link2 back-to-back");
    drain(5, "R1 link5 back-to-back");
  endtask

  task automatic t_disable;
    set_dbg(1'b0);
    fill(200); send_cell(0, 1'b0); idle(4);
    chk("R6", "disabled no entries", link_status, 16'h0000);
    set_dbg(1'b1);
    fill(210); send_cell(0, 1'b0); idle(4);
    chk("R9", "re-enable primes only", link_status, 16'h0000);
    fill(211); send_cell(0, 1'b0); idle(4);
    chk("R6", "enabled entries count", expq[0].size(), 53);
    drain(0, "R6 after re-enable");
  endtask

  task automatic t_icp;
    @(negedge clk); icp_only = 1'b1;
    fill(60); send_cell(3, 1'b1);
    fill(61); send_cell(3, 1'b0); idle(4);
    chk("R7", "non-ICP ignored", link_status, 16'h0000);
    fill(60); send_cell(3, 1'b1); idle(4);
    chk("R7", "reference kept over non-ICP", link_status, 16'h0000);
    cbuf[7] = 8'h99; send_cell(3, 1'b1); idle(4);
    chk("R7", "ICP change seen", link_status, 16'h0008);
    drain(3, "R7 ICP entry");
    @(negedge clk); icp_only = 1'b0;
    fill(62); send_cell(3, 1'b0); idle(4);
    chk("R7", "all-cell mode compares", expq[3].size(), 53);
    drain(3, "R7 all-cell mode");
  endtask

  task automatic t_overflow;
    fill(0); send_cell(4, 1'b0);
    for (int i = 0; i < CL; i++) cbuf[i] = ~cbuf[i];
    send_cell(4, 1'b0);
    fill(0); send_cell(4, 1'b0); idle(4);
    chk("R10", "ovf bit", link_ovf, ovf_exp);
    chk("R10", "ovf expected set", ovf_exp[4], 1'b1);
    chk("R10", "kept entries", expq[4].size(), DEPTH);
    drain(4, "R10 full fifo");
    chk("R10", "ovf sticky after drain", link_ovf[4], 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) mprimed[l] = 0;
    t_reset();
    t_prime_and_diffs();
    t_last_byte();
    t_multi_link();
    t_disable();
    t_icp();
    t_overflow();
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule